// File: doc/BRIEF.md
# Crypto Policy Sequencer

This block loads the protection policy of one external-memory region from a policy RAM. A policy record is six consecutive 32-bit words, and the caller supplies only the address of the first one. A start pulse launches the fetch. The sequencer issues six back-to-back reads, allowing for the one-cycle read latency of the RAM, and collects the returned words. It then publishes every field of the record at once: the access and format codes, the error-mode flag, the two protection-mode flags, a 128-bit key and the address where the region's authentication tags are kept.

From the two protection-mode flags the block also derives a route select. This select steers the region's data through plaintext pass-through, through an authenticate-only path, or through the encrypt-and-authenticate path. A combination with no defined meaning is flagged as a bad policy, and its route is forced to a blocked code. The cipher and hash engines that the route feeds sit outside this block.

Top module: `cpol_seq`

## Requirements
- R1: While reset is high, `rd_en_o`, `busy_o` and `valid_o` are low. Every policy output is zero, which makes `route_o` equal 2'b00 (plaintext).
- R2: A start seen while idle is accepted. Starting in the next cycle, `rd_en_o` is high for exactly six consecutive cycles, and `rd_addr_o` takes the values base, base+1 … base+5, wrapping modulo 2^AW.
- R3: `valid_o` is a single-cycle pulse, seven cycles after the clock edge that accepted the start. `busy_o` is high from the cycle after that edge through the cycle before `valid_o`, and it is low while `valid_o` is high.
- R4: Bits of the first record word are decoded as follows. Bit 0 is the integrity mode on `integ_o`. Bit 1 is the confidentiality mode on `conf_o`. Bit 2 is the error-mode flag on `errmode_o`. Bits 4:3 are the format code on `format_o`. Bits 6:5 are the access code on `access_o`.
- R5: `key_o` equals the concatenation of record words 2, 3, 4 and 5, with word 2 in bits 127:96 and word 5 in bits 31:0.
- R6: `tag_addr_o` equals record word 6.
- R7: `route_o` encodes the path. 2'b10 is encrypt plus authenticate, selected when both mode bits are set. 2'b01 is authenticate only, selected when only the integrity bit is set. 2'b00 is plaintext, selected when both bits are clear.
- R8: When the confidentiality bit is set and the integrity bit is clear, `route_o` is 2'b11 (blocked) and `bad_policy_o` is high. For every other combination, `bad_policy_o` is low.
- R9: A start that arrives while a fetch is busy is ignored. This includes a start in the last busy cycle. It causes no extra reads, no change of address sequence and no extra `valid_o` pulse.
- R10: All policy outputs, including the route and the bad-policy flag, keep their values from one `valid_o` pulse until the next. While a new fetch runs, they still show the previous record.
- R11: Bits 31:7 of the first record word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a policy fetch |
| base_i | input | AW | Address of the first record word |
| rd_en_o | output | 1 | Policy RAM read enable |
| rd_addr_o | output | AW | Policy RAM read address |
| rd_data_i | input | DW | Policy RAM read data, one cycle after the address |
| busy_o | output | 1 | Fetch in progress |
| valid_o | output | 1 | One-cycle pulse: new policy published |
| access_o | output | 2 | Access code |
| format_o | output | 2 | Format code |
| errmode_o | output | 1 | Error-mode flag |
| conf_o | output | 1 | Confidentiality mode |
| integ_o | output | 1 | Integrity mode |
| key_o | output | KEY_W | Region key |
| tag_addr_o | output | DW | Tag storage address |
| route_o | output | 2 | Datapath route select |
| bad_policy_o | output | 1 | Undefined mode combination |

## Verification
The bench builds the sequencer with AW=4, which gives a 16-word policy RAM. This lets the bench start a fetch from every base address, including the bases whose six-word record wraps past the top of the RAM. It also sweeps all 128 patterns of the seven decoded bits of the first word, each with noisy padding bits. It injects stray starts in an early busy cycle and in the last busy cycle. During every fetch it checks that the previous record stays visible until the new pulse.

// File: rtl/cpol_pkg.sv
package cpol_pkg;

  typedef enum logic [1:0] {
    ROUTE_PLAIN = 2'b00,
    ROUTE_AUTH  = 2'b01,
    ROUTE_SEAL  = 2'b10,
    ROUTE_BLOCK = 2'b11
  } route_t;

  // bit positions inside the first record word (decoded downstream)
  localparam int unsigned B_INTEG  = 0;
  localparam int unsigned B_CONF   = 1;
  localparam int unsigned B_ERRM   = 2;
  localparam int unsigned B_FMT_LO = 3;
  localparam int unsigned B_ACC_LO = 5;
  localparam int unsigned B_USED   = 7;

endpackage

// File: rtl/cpol_addr_seq.sv
module cpol_addr_seq #(
  parameter int unsigned AW = 10,
  parameter int unsigned NW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [AW-1:0] base_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o
);
  localparam int unsigned CW = $clog2(NW);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
      cnt_q     <= '0;
    end else if (go_i) begin
      rd_en_o   <= 1'b1;
      rd_addr_o <= base_i;
      cnt_q     <= '0;
    end else if (rd_en_o) begin
      if (cnt_q == CW'(NW - 1)) begin
        rd_en_o <= 1'b0;
      end else begin
        rd_addr_o <= rd_addr_o + AW'(1);
        cnt_q     <= cnt_q + CW'(1);
      end
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + AW'(1)));

endmodule

// File: rtl/cpol_word_collect.sv
module cpol_word_collect #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en_i,
  input  logic [DW-1:0]          rd_data_i,
  output logic                   take_last_o,
  output logic [1:0]             sh_mode_o,
  output logic                   done_o,
  output logic [NW-1:0][DW-1:0]  rec_o
);
  localparam int unsigned IW = $clog2(NW);

  logic                  rvalid_q;
  logic [IW-1:0]         idx_q;
  logic [NW-2:0][DW-1:0] shadow_q;

  assign take_last_o = rvalid_q && (idx_q == IW'(NW - 1));
  assign sh_mode_o   = shadow_q[0][1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      rvalid_q <= rd_en_i;
      if (take_last_o)   idx_q <= '0;
      else if (rvalid_q) idx_q <= idx_q + IW'(1);
    end
  end

  for (genvar k = 0; k < NW - 1; k++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)                                  shadow_q[k] <= '0;
      else if (rvalid_q && idx_q == IW'(k))     shadow_q[k] <= rd_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= take_last_o;
      if (take_last_o) rec_o <= {rd_data_i, shadow_q};
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/cpol_route_dec.sv
module cpol_route_dec
  import cpol_pkg::*;
(
  input  logic   conf_i,
  input  logic   integ_i,
  output route_t route_o,
  output logic   bad_o
);
  always_comb begin
    bad_o = 1'b0;
    unique case ({conf_i, integ_i})
      2'b11:   route_o = ROUTE_SEAL;
      2'b01:   route_o = ROUTE_AUTH;
      2'b00:   route_o = ROUTE_PLAIN;
      default: begin
        route_o = ROUTE_BLOCK;
        bad_o   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/cpol_seq.sv
module cpol_seq
  import cpol_pkg::*;
#(
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 32,
  parameter int unsigned KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [DW-1:0]    rd_data_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [1:0]       access_o,
  output logic [1:0]       format_o,
  output logic             errmode_o,
  output logic             conf_o,
  output logic             integ_o,
  output logic [KEY_W-1:0] key_o,
  output logic [DW-1:0]    tag_addr_o,
  output logic [1:0]       route_o,
  output logic             bad_policy_o
);
  localparam int unsigned KW = KEY_W / DW;
  localparam int unsigned NW = KW + 2;

  logic                  busy_q;
  logic                  go;
  logic                  take_last;
  logic [1:0]            sh_mode;
  logic [NW-1:0][DW-1:0] rec;
  route_t                dec_route;
  logic                  dec_bad;
  route_t                route_q;
  logic                  bad_q;
  logic                  unused_pad;

  assign go = start_i && !busy_q;

  always_ff @(posedge clk) begin
    if (rst)            busy_q <= 1'b0;
    else if (go)        busy_q <= 1'b1;
    else if (take_last) busy_q <= 1'b0;
  end

  cpol_addr_seq #(.AW(AW), .NW(NW)) u_addr (
    .clk(clk), .rst(rst), .go_i(go), .base_i(base_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o)
  );

  cpol_word_collect #(.DW(DW), .NW(NW)) u_coll (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_o), .rd_data_i(rd_data_i),
    .take_last_o(take_last), .sh_mode_o(sh_mode),
    .done_o(valid_o), .rec_o(rec)
  );

  cpol_route_dec u_dec (
    .conf_i(sh_mode[B_CONF]), .integ_i(sh_mode[B_INTEG]),
    .route_o(dec_route), .bad_o(dec_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= ROUTE_PLAIN;
      bad_q   <= 1'b0;
    end else if (take_last) begin
      route_q <= dec_route;
      bad_q   <= dec_bad;
    end
  end

  assign busy_o       = busy_q;
  assign route_o      = route_q;
  assign bad_policy_o = bad_q;
  assign integ_o      = rec[0][B_INTEG];
  assign conf_o       = rec[0][B_CONF];
  assign errmode_o    = rec[0][B_ERRM];
  assign format_o     = rec[0][B_FMT_LO +: 2];
  assign access_o     = rec[0][B_ACC_LO +: 2];
  assign unused_pad   = ^rec[0][DW-1:B_USED];
  assign tag_addr_o   = rec[NW-1];

  for (genvar k = 0; k < KW; k++) begin : g_key
    assign key_o[KEY_W-1-k*DW -: DW] = rec[1+k];
  end

  // R9
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en_o) |-> $past(start_i && !busy_q));

  // R8
  bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && conf_o && !integ_o) |-> (route_o == 2'b11 && bad_policy_o));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(key_o) && $stable(tag_addr_o) && $stable(route_o)));

  // R3
  busy_valid_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !busy_o);

endmodule

// File: tb/cpol_seq_bench.sv
`timescale 1ns/1ps
module cpol_seq_bench;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic          rd_en_o;
  logic [AW-1:0] rd_addr_o;
  logic [31:0]   rd_data_i;
  logic          busy_o, valid_o, errmode_o, conf_o, integ_o, bad_policy_o;
  logic [1:0]    access_o, format_o, route_o;
  logic [127:0]  key_o;
  logic [31:0]   tag_addr_o;

  logic [31:0] mem [DEPTH];
  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [127:0] prev_key = '0;
  logic [31:0]  prev_tag = '0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o];

  cpol_seq #(.AW(AW), .DW(32), .KEY_W(128)) u_cpol_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .valid_o(valid_o), .access_o(access_o),
    .format_o(format_o), .errmode_o(errmode_o), .conf_o(conf_o),
    .integ_o(integ_o), .key_o(key_o), .tag_addr_o(tag_addr_o),
    .route_o(route_o), .bad_policy_o(bad_policy_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_word(int k, int base, int seed);
    return (32'h9E3779B9 * (k + 1)) ^ (seed << 8) ^ base ^ (k << 28);
  endfunction

  // inj: busy cycle index at which a stray start is driven (-1: none)
  task automatic fetch(input int base, input logic [31:0] w0, input int seed,
                       input int inj, input int alt);
    logic [31:0] w [6];
    logic [1:0]  exp_route;
    logic        exp_bad;
    w[0] = w0;
    for (int k = 1; k < 6; k++) w[k] = gen_word(k, base, seed);
    for (int k = 0; k < 6; k++) mem[(base + k) % DEPTH] = w[k];
    @(negedge clk);
    start_i = 1'b1;
    base_i  = AW'(base);
    @(negedge clk);
    for (int j = 0; j < 8; j++) begin
      start_i = (j == inj);
      if (j == inj) base_i = AW'(alt);
      if (j < 6) begin
        chk("R2 rd_en", 128'(rd_en_o), 128'(1));
        chk("R2 addr", 128'(rd_addr_o), 128'((base + j) % DEPTH));
      end else begin
        chk("R2 rd_en off", 128'(rd_en_o), 128'(0));
      end
      chk("R3 busy", 128'(busy_o), 128'(j < 7));
      chk("R3 valid", 128'(valid_o), 128'(j == 7));
      if (j < 7) begin
        chk("R10 key held", key_o, prev_key);
        chk("R10 tag held", 128'(tag_addr_o), 128'(prev_tag));
      end
      if (j < 7) @(negedge clk);
    end
    start_i = 1'b0;
    unique case (w0[1:0])
      2'b11: begin exp_route = 2'b10; exp_bad = 1'b0; end
      2'b01: begin exp_route = 2'b01; exp_bad = 1'b0; end
      2'b00: begin exp_route = 2'b00; exp_bad = 1'b0; end
      default: begin exp_route = 2'b11; exp_bad = 1'b1; end
    endcase
    // R4 / R11: only bits 6:0 of word 0 matter
    chk("R4 integ", 128'(integ_o), 128'(w0[0]));
    chk("R4 conf", 128'(conf_o), 128'(w0[1]));
    chk("R4 errmode", 128'(errmode_o), 128'(w0[2]));
    chk("R4 format", 128'(format_o), 128'(w0[4:3]));
    chk("R4 access", 128'(access_o), 128'(w0[6:5]));
    chk("R5 key", key_o, {w[1], w[2], w[3], w[4]});
    chk("R6 tag", 128'(tag_addr_o), 128'(w[5]));
    chk("R7 route", 128'(route_o), 128'(exp_route));
    chk("R8 bad policy", 128'(bad_policy_o), 128'(exp_bad));
    prev_key = {w[1], w[2], w[3], w[4]};
    prev_tag = w[5];
    @(negedge clk);
    chk("R3 valid one cycle", 128'(valid_o), 128'(0));
    if (inj >= 0) begin
      for (int q = 0; q < 3; q++) begin
        chk("R9 no extra read", 128'(rd_en_o), 128'(0));
        chk("R9 no extra valid", 128'(valid_o), 128'(0));
        chk("R10 key after stray", key_o, prev_key);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'hA5A5_0000 + i;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_en", 128'(rd_en_o), 128'(0));
    chk("R1 busy", 128'(busy_o), 128'(0));
    chk("R1 valid", 128'(valid_o), 128'(0));
    chk("R1 key", key_o, 128'(0));
    chk("R1 tag", 128'(tag_addr_o), 128'(0));
    chk("R1 route", 128'(route_o), 128'(0));
    chk("R1 mode bits", 128'({access_o, format_o, errmode_o, conf_o, integ_o, bad_policy_o}), 128'(0));
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", 128'({rd_en_o, busy_o, valid_o}), 128'(0));

    // every base, including wrapping records (R2)
    for (int b = 0; b < DEPTH; b++)
      fetch(b, ((b * 37) & 32'h7F) | ((b % 2 == 1) ? 32'hFFFF_FF80 : 32'h0), b, -1, 0);

    // every decoded pattern of word 0 with noisy padding (R4, R7, R8, R11)
    for (int v = 0; v < 128; v++)
      fetch(v % DEPTH, 32'(v) | ((32'(v) * 32'h0101_0101) << 7), v + 100, -1, 0);

    // stray starts while busy (R9): early and in the last busy cycle
    fetch(3, 32'h0000_0063, 500, 2, 9);
    fetch(12, 32'h0000_0042, 501, 6, 1);
    fetch(15, 32'h0000_0001, 502, 0, 7);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule